// File: doc/BRIEF.md
# Single-Vector Interrupt Entry Controller

This block is the interrupt side of a 32-bit soft RISC core. It samples thirty-two level-sensitive request lines into a pending register. A per-line mask register gates them, and a global enable bit decides whether an exception may be raised at all. When the core reports an instruction boundary, the enable is set, and at least one pending line is also unmasked, the block raises an exception. It redirects fetch to a programmable base plus a fixed offset of 0xC0. It also hands the address of the next instruction to the register file as the exception address.

On entry the global enable is copied into a shadow bit and then cleared, so a handler cannot be interrupted again. A return-from-exception strobe copies the shadow bit back into the enable and redirects fetch to the saved exception address. Software reaches the status, mask, pending and base registers through one CSR read port and one CSR write port. The handler finds the source to serve by reading the pending and mask registers.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset, the status, mask and pending CSRs read 0 and the base CSR reads BASE_RESET. CSR select encoding: 0 status, 1 mask, 2 pending, 3 base.
- R2: A request line that is high at a clock edge sets its pending bit, and the bit stays set after the line drops.
- R3: Writing the pending CSR clears each bit written as 1. A bit whose line is high in the same cycle stays set.
- R4: `takeExc` is high exactly when the enable is 1, pending AND mask is nonzero, and `atBoundary` is high.
- R5: While `takeExc` is high, `fetchRedirect` is high, `fetchTarget` equals base + 0xC0, `epcWrEn` is high and `epcWrData` equals `nextPc`.
- R6: After an entry the status CSR reads the old enable in bit 1 (shadow) and 0 in bit 0 (enable).
- R7: While the enable is 0, `takeExc` stays low whatever is pending and unmasked.
- R8: An `eretStrobe` raises `fetchRedirect` with `fetchTarget` equal to the address saved at the last entry. After the edge, bit 0 of the status CSR equals bit 1.
- R9: If an entry and a status CSR write fall in the same cycle, the entry decides both status bits.
- R10: The two low bits of the base CSR always read 0, whatever value is written.
- R11: The mask CSR reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 32 | Level-sensitive interrupt request lines |
| atBoundary | input | 1 | Core is at an instruction boundary and may take an exception |
| nextPc | input | 32 | Address of the next instruction to execute |
| eretStrobe | input | 1 | Return-from-exception strobe |
| csrWrEn | input | 1 | CSR write strobe |
| csrSel | input | 2 | CSR select: 0 status, 1 mask, 2 pending, 3 base |
| csrWrData | input | 32 | CSR write data; status uses bit 0 enable, bit 1 shadow |
| csrRdData | output | 32 | Combinational read data of the selected CSR |
| takeExc | output | 1 | Exception is taken this cycle |
| fetchRedirect | output | 1 | Fetch must jump to fetchTarget |
| fetchTarget | output | 32 | Vector on entry, saved address on return |
| epcWrEn | output | 1 | Write strobe for the exception-address register |
| epcWrData | output | 32 | Value for the exception-address register |

## Verification
The assertions assume that `eretStrobe` is asserted only inside a handler, so it never meets a live request while the enable is set. They also assume that the request lines and CSR inputs are stable around the clock edge. The bench drives every input just after the falling edge and releases `atBoundary` before the next rising edge whenever it only wants to observe a request. It pulses `eretStrobe` only after an entry has cleared the enable. The one case where an entry and a CSR write share a cycle is created on purpose, to test the priority rule.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_PEND   = 2'd2,
    SEL_BASE   = 2'd3
  } csr_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;
    logic eret;
    logic wrStatus;
    logic wrMask;
    logic wrPend;
    logic wrBase;
  } entry_ctl_t;

  localparam int unsigned STATUS_IE_BIT  = 0;
  localparam int unsigned STATUS_EIE_BIT = 1;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ieQ,
  input  logic       anyLive,
  input  logic       atBoundary,
  input  logic       eretStrobe,
  input  logic       csrWrEn,
  input  logic [1:0] csrSel,
  output entry_ctl_t ctl
);

  csr_sel_e selE;
  logic     reqLive;

  always_comb begin
    selE    = csr_sel_e'(csrSel);
    reqLive = ieQ && anyLive;

    ctl          = '0;
    ctl.take     = reqLive && atBoundary;
    ctl.eret     = eretStrobe && !ctl.take;
    ctl.wrStatus = csrWrEn && (selE == SEL_STATUS);
    ctl.wrMask   = csrWrEn && (selE == SEL_MASK);
    ctl.wrPend   = csrWrEn && (selE == SEL_PEND);
    ctl.wrBase   = csrWrEn && (selE == SEL_BASE);
  end

  // R7: no entry while the enable is clear
  p_take_needs_ie_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> ieQ);

  // R4: entry only at an instruction boundary with a live source
  p_take_at_boundary_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> (atBoundary && anyLive));

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned XLEN       = 32,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_00C0,
  parameter logic [31:0] BASE_RESET = 32'h0000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  entry_ctl_t           ctl,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [XLEN-1:0]      nextPc,
  input  logic [1:0]           csrSel,
  input  logic [XLEN-1:0]      csrWrData,
  output logic                 ieQ,
  output logic                 anyLive,
  output logic [XLEN-1:0]      csrRdData,
  output logic                 fetchRedirect,
  output logic [XLEN-1:0]      fetchTarget,
  output logic                 epcWrEn,
  output logic [XLEN-1:0]      epcWrData
);

  localparam int unsigned ALIGN_BITS = 2;

  logic                 eieQ;
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] maskQ;
  logic [XLEN-1:0]      baseQ;
  logic [XLEN-1:0]      epcQ;
  logic [XLEN-1:0]      vecAddr;

  // one pending flop per line; set wins over write-one-to-clear
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_pend
    logic clrBit;
    assign clrBit = ctl.wrPend && csrWrData[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            pendQ[g] <= 1'b0;
      else if (irqLines[g]) pendQ[g] <= 1'b1;
      else if (clrBit)      pendQ[g] <= 1'b0;
    end
  end

  // enable and shadow: entry > return > software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ  <= 1'b0;
      eieQ <= 1'b0;
    end else if (ctl.take) begin
      eieQ <= ieQ;
      ieQ  <= 1'b0;
    end else if (ctl.eret) begin
      ieQ  <= eieQ;
    end else if (ctl.wrStatus) begin
      ieQ  <= csrWrData[STATUS_IE_BIT];
      eieQ <= csrWrData[STATUS_EIE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      baseQ <= {BASE_RESET[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      epcQ  <= '0;
    end else begin
      if (ctl.wrMask) maskQ <= csrWrData[NUM_LINES-1:0];
      if (ctl.wrBase) baseQ <= {csrWrData[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (ctl.take)   epcQ  <= nextPc;
    end
  end

  always_comb begin
    anyLive = |(pendQ & maskQ);
    vecAddr = baseQ + VEC_OFFSET[XLEN-1:0];

    fetchRedirect = ctl.take || ctl.eret;
    if (ctl.take)      fetchTarget = vecAddr;
    else if (ctl.eret) fetchTarget = epcQ;
    else               fetchTarget = '0;

    epcWrEn   = ctl.take;
    epcWrData = nextPc;

    csrRdData = '0;
    case (csr_sel_e'(csrSel))
      SEL_STATUS: begin
        csrRdData[STATUS_IE_BIT]  = ieQ;
        csrRdData[STATUS_EIE_BIT] = eieQ;
      end
      SEL_MASK: csrRdData[NUM_LINES-1:0] = maskQ;
      SEL_PEND: csrRdData[NUM_LINES-1:0] = pendQ;
      SEL_BASE: csrRdData = baseQ;
      default:  csrRdData = '0;
    endcase
  end

  // R6: entry leaves the enable clear and the shadow holding the old enable
  p_entry_clears_ie_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |=> (!ieQ && eieQ));

  // R2: a line high at an edge is pending after it
  p_line_sets_pend_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && (irqLines != '0)) |=> ((pendQ & $past(irqLines)) == $past(irqLines)));

  // R8: a return restores the enable from the shadow
  p_eret_restores_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.eret |=> (ieQ == $past(eieQ)));

  // R10: the vector is word aligned
  p_vec_aligned_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> (fetchTarget[ALIGN_BITS-1:0] == '0));

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned XLEN       = 32,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_00C0,
  parameter logic [31:0] BASE_RESET = 32'h0000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 atBoundary,
  input  logic [XLEN-1:0]      nextPc,
  input  logic                 eretStrobe,
  input  logic                 csrWrEn,
  input  logic [1:0]           csrSel,
  input  logic [XLEN-1:0]      csrWrData,
  output logic [XLEN-1:0]      csrRdData,
  output logic                 takeExc,
  output logic                 fetchRedirect,
  output logic [XLEN-1:0]      fetchTarget,
  output logic                 epcWrEn,
  output logic [XLEN-1:0]      epcWrData
);

  entry_ctl_t ctl;
  logic       ieQ;
  logic       anyLive;

  irq_entry_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ieQ        (ieQ),
    .anyLive    (anyLive),
    .atBoundary (atBoundary),
    .eretStrobe (eretStrobe),
    .csrWrEn    (csrWrEn),
    .csrSel     (csrSel),
    .ctl        (ctl)
  );

  irq_entry_dp #(
    .NUM_LINES  (NUM_LINES),
    .XLEN       (XLEN),
    .VEC_OFFSET (VEC_OFFSET),
    .BASE_RESET (BASE_RESET)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .irqLines      (irqLines),
    .nextPc        (nextPc),
    .csrSel        (csrSel),
    .csrWrData     (csrWrData),
    .ieQ           (ieQ),
    .anyLive       (anyLive),
    .csrRdData     (csrRdData),
    .fetchRedirect (fetchRedirect),
    .fetchTarget   (fetchTarget),
    .epcWrEn       (epcWrEn),
    .epcWrData     (epcWrData)
  );

  assign takeExc = ctl.take;

endmodule

// File: tb/irq_entry_unit_bench.sv
module irq_entry_unit_bench;

  localparam logic [31:0] RST_BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqLines = '0;
  logic        atBoundary = 1'b0;
  logic [31:0] nextPc = '0;
  logic        eretStrobe = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [1:0]  csrSel = '0;
  logic [31:0] csrWrData = '0;
  logic [31:0] csrRdData;
  logic        takeExc;
  logic        fetchRedirect;
  logic [31:0] fetchTarget;
  logic        epcWrEn;
  logic [31:0] epcWrData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_entry_unit #(.BASE_RESET(RST_BASE)) u_irq_entry_unit (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .atBoundary(atBoundary),
    .nextPc(nextPc), .eretStrobe(eretStrobe), .csrWrEn(csrWrEn),
    .csrSel(csrSel), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .takeExc(takeExc), .fetchRedirect(fetchRedirect), .fetchTarget(fetchTarget),
    .epcWrEn(epcWrEn), .epcWrData(epcWrData)
  );

  typedef struct packed {
    logic [31:0] lines;
    logic [31:0] mask;
    logic        ie;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{32'h0000_0001, 32'h0000_0001, 1'b1},
    '{32'h0000_0001, 32'h0000_0002, 1'b1},
    '{32'h8000_0000, 32'hFFFF_FFFF, 1'b1},
    '{32'h8000_0000, 32'h7FFF_FFFF, 1'b1},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
    '{32'h0000_0000, 32'hFFFF_FFFF, 1'b1},
    '{32'h00F0_0000, 32'h0010_0000, 1'b1},
    '{32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all drive happens just after a falling edge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic csrWrite(input logic [1:0] sel, input logic [31:0] data);
    csrWrEn = 1'b1; csrSel = sel; csrWrData = data;
    cycle();
    csrWrEn = 1'b0; csrWrData = '0;
  endtask

  task automatic csrRead(input logic [1:0] sel, output logic [31:0] data);
    csrSel = sel;
    #1 data = csrRdData;
  endtask

  task automatic pulseLines(input logic [31:0] lines);
    irqLines = lines;
    cycle();
    irqLines = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic        expTake;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    csrRead(2'd0, rd); check("R1 status", rd, 32'h0);
    csrRead(2'd1, rd); check("R1 mask", rd, 32'h0);
    csrRead(2'd2, rd); check("R1 pending", rd, 32'h0);
    csrRead(2'd3, rd); check("R1 base", rd, RST_BASE);

    // vector table: mask, pend, enable -> request
    for (int i = 0; i < 8; i++) begin
      csrWrite(2'd0, 32'h0);
      csrWrite(2'd2, 32'hFFFF_FFFF);
      csrWrite(2'd1, VECS[i].mask);
      csrRead(2'd1, rd); check("R11 mask readback", rd, VECS[i].mask);
      pulseLines(VECS[i].lines);
      csrRead(2'd2, rd); check("R2 pending held", rd, VECS[i].lines);
      csrWrite(2'd0, {31'h0, VECS[i].ie});
      expTake = VECS[i].ie && ((VECS[i].lines & VECS[i].mask) != 0);
      nextPc = 32'h0000_2000 + i * 4;
      atBoundary = 1'b1;
      #1;
      check(VECS[i].ie ? "R4 take" : "R7 take with enable clear", {31'h0, takeExc}, {31'h0, expTake});
      if (expTake) begin
        check("R5 target", fetchTarget, RST_BASE + 32'hC0);
        check("R5 epc data", epcWrData, nextPc);
      end
      atBoundary = 1'b0;
      #1;
      check("R4 no boundary", {31'h0, takeExc}, 32'h0);
    end

    // R3 write-one-to-clear, set wins while the line is high
    csrWrite(2'd0, 32'h0);
    csrWrite(2'd2, 32'hFFFF_FFFF);
    pulseLines(32'h0000_0120);
    csrWrite(2'd2, 32'h0000_0020);
    csrRead(2'd2, rd); check("R3 clear one bit", rd, 32'h0000_0100);
    irqLines = 32'h0000_0100;
    csrWrite(2'd2, 32'h0000_0100);
    csrRead(2'd2, rd); check("R3 set beats clear", rd, 32'h0000_0100);
    irqLines = '0;
    csrWrite(2'd2, 32'h0000_0100);
    csrRead(2'd2, rd); check("R3 cleared", rd, 32'h0);

    // R10 base alignment
    csrWrite(2'd3, 32'h4000_0003);
    csrRead(2'd3, rd); check("R10 base low bits", rd, 32'h4000_0000);

    // R5/R6 entry, R7 no nesting, R8 return
    csrWrite(2'd1, 32'h0000_0008);
    pulseLines(32'h0000_0008);
    csrWrite(2'd0, 32'h1);
    nextPc = 32'h0000_0400;
    atBoundary = 1'b1;
    #1;
    check("R5 take", {31'h0, takeExc}, 32'h1);
    check("R5 redirect", {31'h0, fetchRedirect}, 32'h1);
    check("R5 vector", fetchTarget, 32'h4000_00C0);
    check("R5 epc strobe", {31'h0, epcWrEn}, 32'h1);
    check("R5 epc value", epcWrData, 32'h0000_0400);
    cycle();
    nextPc = 32'h0000_0500;
    csrRead(2'd0, rd); check("R6 status after entry", rd, 32'h2);
    #1;
    check("R7 no nested take", {31'h0, takeExc}, 32'h0);
    atBoundary = 1'b0;
    eretStrobe = 1'b1;
    #1;
    check("R8 redirect", {31'h0, fetchRedirect}, 32'h1);
    check("R8 return target", fetchTarget, 32'h0000_0400);
    cycle();
    eretStrobe = 1'b0;
    csrRead(2'd0, rd); check("R8 enable restored", rd, 32'h3);

    // R9 entry beats a same-cycle status write (pending bit 3 still set)
    csrWrite(2'd0, 32'h1);
    atBoundary = 1'b1;
    csrWrEn = 1'b1; csrSel = 2'd0; csrWrData = 32'h1;
    cycle();
    csrWrEn = 1'b0; atBoundary = 1'b0;
    csrRead(2'd0, rd); check("R9 entry wins", rd, 32'h2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule